// File: doc/BRIEF.md
# Skip Condition Evaluator

This block decides, for an 18-bit word-oriented processor, whether the instruction after a conditional-skip instruction should be passed over. The sequencer presents the instruction word with a valid strobe, together with the current accumulator, the second working register (called the I register here), the overflow flag, six program flags and six sense switches. One clock later the block reports whether to skip. It also reports whether the overflow flag must be cleared.

Each of the twelve low bits of the word enables one test. The tests cover the accumulator, the I register, the overflow flag, one or all program flags, and one or all sense switches. The block skips when any enabled test holds. An invert bit turns that decision into its opposite. Any word that enables the overflow test also requests that the flag be cleared, whatever the skip result. The block does not update the program counter and does not store the flag; those tasks belong to the surrounding sequencer.

Top module: `skip_eval`

## Requirements
- R1: A word is a skip word only when instr[17:13] = 5'b11010. instr[12] is the invert bit and instr[11:0] are the test enables. A valid word with any other opcode drives both outputs low.
- R2: Accumulator tests. instr[6] tests acc = 0. instr[7] tests acc[17] = 0. instr[8] tests acc[17] = 1.
- R3: I register tests. instr[10] tests io[17] = 0. instr[11] tests io != 0.
- R4: instr[9] tests that the overflow input is 0.
- R5: instr[2:0] selects a program flag. A value n from 1 to 6 tests flags[n-1] = 0. The value 7 tests that all six flags are 0. The value 0 adds no test.
- R6: instr[5:3] selects a sense switch. The value n from 1 to 6 tests switches[n-1] = 0. The value 7 tests that all six switches are 0. The value 0 adds no test.
- R7: The skip decision is the OR of every enabled test. With no test enabled, the decision is 0.
- R8: With instr[12] set, skip_taken is the inverse of the decision that the same word without instr[12] would give.
- R9: ovf_clear is 1 for every valid skip word with instr[9] set. This holds whatever the skip outcome and whatever the invert bit.
- R10: Both outputs are registered. They appear in the cycle after the clock edge that samples instr_valid = 1, and they last one cycle. They are 0 after a cycle without a valid strobe and while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 18 | Instruction word |
| acc | input | 18 | Accumulator contents |
| io | input | 18 | I register contents |
| ovf | input | 1 | Overflow flag |
| flags | input | 6 | Program flags, flag n on bit n-1 |
| switches | input | 6 | Sense switches, switch n on bit n-1 |
| skip_taken | output | 1 | Skip the next instruction |
| ovf_clear | output | 1 | Clear the overflow flag |

## Verification
The assertions check three things on every cycle. Neither output pulses without a valid strobe in the cycle before. The clear request follows the overflow enable of the previous word. When a word enables no test, or only the accumulator sign test, the skip result equals the invert bit or the sampled accumulator sign. Behaviours that depend on the exact data values are shown only by the bench scenarios. These are the flag and switch selector codes, including the all-off code and the empty code, the OR of several tests, and the inversion of compound decisions.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;
  localparam int WORD_W = 18;
  localparam int OPC_W  = 5;
  localparam int SEL_W  = 3;
  localparam int NSEL   = 6;
  localparam logic [OPC_W-1:0] SKIP_OPC = 5'b11010;

  // Field order follows the bit positions that the sequencer encodes.
  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             inv;
    logic             i_nz;
    logic             i_pos;
    logic             ovf_z;
    logic             a_neg;
    logic             a_pos;
    logic             a_zero;
    logic [SEL_W-1:0] sw_sel;
    logic [SEL_W-1:0] fl_sel;
  } skip_word_t;
endpackage

// File: rtl/skip_sel_test.sv
module skip_sel_test #(
  parameter int N     = 6,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [N-1:0]     vec,
  output logic             hit
);
  localparam logic [SEL_W-1:0] ALL_CODE = {SEL_W{1'b1}};

  logic [N-1:0] one_hit;

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_bit
      assign one_hit[k] = (sel == SEL_W'(k + 1)) && !vec[k];
    end
  endgenerate

  assign hit = (|one_hit) || ((sel == ALL_CODE) && (vec == '0));
endmodule

// File: rtl/skip_reg_test.sv
module skip_reg_test #(
  parameter int W = 18
) (
  input  logic         en_a_zero,
  input  logic         en_a_pos,
  input  logic         en_a_neg,
  input  logic         en_ovf_z,
  input  logic         en_i_pos,
  input  logic         en_i_nz,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] io,
  input  logic         ovf,
  output logic         hit
);
  logic a_is_zero, a_sign, i_sign, i_is_zero;

  always_comb begin
    a_is_zero = (acc == '0);
    a_sign    = acc[W-1];
    i_sign    = io[W-1];
    i_is_zero = (io == '0);
    hit = (en_a_zero && a_is_zero) ||
          (en_a_pos  && !a_sign)   ||
          (en_a_neg  && a_sign)    ||
          (en_ovf_z  && !ovf)      ||
          (en_i_pos  && !i_sign)   ||
          (en_i_nz   && !i_is_zero);
  end
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_eval_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] acc,
  input  logic [WORD_W-1:0] io,
  input  logic              ovf,
  input  logic [NSEL-1:0]   flags,
  input  logic [NSEL-1:0]   switches,
  output logic              skip_taken,
  output logic              ovf_clear
);
  skip_word_t w;
  logic reg_hit, flag_hit, sw_hit;
  logic is_skip, decision;
  logic skip_nx, clr_nx;
  logic skip_q, clr_q;

  assign w = skip_word_t'(instr);

  skip_reg_test #(.W(WORD_W)) u_reg (
    .en_a_zero (w.a_zero),
    .en_a_pos  (w.a_pos),
    .en_a_neg  (w.a_neg),
    .en_ovf_z  (w.ovf_z),
    .en_i_pos  (w.i_pos),
    .en_i_nz   (w.i_nz),
    .acc       (acc),
    .io        (io),
    .ovf       (ovf),
    .hit       (reg_hit)
  );

  skip_sel_test #(.N(NSEL), .SEL_W(SEL_W)) u_flag (
    .sel (w.fl_sel),
    .vec (flags),
    .hit (flag_hit)
  );

  skip_sel_test #(.N(NSEL), .SEL_W(SEL_W)) u_sw (
    .sel (w.sw_sel),
    .vec (switches),
    .hit (sw_hit)
  );

  // Next-state logic
  always_comb begin
    is_skip  = instr_valid && (w.opc == SKIP_OPC);
    decision = reg_hit || flag_hit || sw_hit;
    skip_nx  = is_skip && (decision ^ w.inv);
    clr_nx   = is_skip && w.ovf_z;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      skip_q <= skip_nx;
      clr_q  <= clr_nx;
    end
  end

  assign skip_taken = skip_q;
  assign ovf_clear  = clr_q;
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk
  import skip_eval_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr,
  input logic [WORD_W-1:0] acc,
  input logic              skip_taken,
  input logic              ovf_clear
);
  logic opc_ok;
  assign opc_ok = (instr[WORD_W-1 -: OPC_W] == SKIP_OPC);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!skip_taken && !ovf_clear));

  // R9
  clear_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opc_ok) |=> (ovf_clear == $past(instr[9])));

  // R1
  foreign_opc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !opc_ok) |=> (!skip_taken && !ovf_clear));

  // R8
  empty_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opc_ok && instr[11:0] == 12'd0) |=> (skip_taken == $past(instr[12])));

  // R2
  acc_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && opc_ok && instr[12:0] == 13'o0400) |=> (skip_taken == $past(acc[WORD_W-1])));
endmodule

bind skip_eval skip_eval_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .acc         (acc),
  .skip_taken  (skip_taken),
  .ovf_clear   (ovf_clear)
);

// File: tb/skip_eval_tb.sv
module skip_eval_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [17:0] instr, acc, io;
  logic        ovf;
  logic [5:0]  flags, switches;
  logic        skip_taken, ovf_clear;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  skip_eval u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .acc(acc), .io(io), .ovf(ovf), .flags(flags), .switches(switches),
    .skip_taken(skip_taken), .ovf_clear(ovf_clear)
  );

  function automatic logic sel_ok(input logic [2:0] n, input logic [5:0] v);
    if (n == 3'd7) return (v == 6'd0);
    if (n == 3'd0) return 1'b0;
    return !v[n-1];
  endfunction

  // returns {skip, clear}
  function automatic logic [1:0] model(input logic vld, input logic [17:0] w,
      input logic [17:0] a, input logic [17:0] i, input logic o,
      input logic [5:0] f, input logic [5:0] s);
    logic hit;
    if (!vld || w[17:13] != 5'b11010) return 2'b00;
    hit = 1'b0;
    if ((w & 18'o000100) != 0 && a == 0) hit = 1'b1;
    if ((w & 18'o000200) != 0 && !a[17]) hit = 1'b1;
    if ((w & 18'o000400) != 0 && a[17])  hit = 1'b1;
    if ((w & 18'o001000) != 0 && !o)     hit = 1'b1;
    if ((w & 18'o002000) != 0 && !i[17]) hit = 1'b1;
    if ((w & 18'o004000) != 0 && i != 0) hit = 1'b1;
    if (sel_ok(w[2:0], f)) hit = 1'b1;
    if (sel_ok(w[5:3], s)) hit = 1'b1;
    return {hit ^ w[12], w[9]};
  endfunction

  task automatic compare(input string tag, input logic [1:0] exp);
    checks++;
    if ({skip_taken, ovf_clear} !== exp) begin
      errors++;
      $display("FAIL %s: got skip=%b clr=%b, expected skip=%b clr=%b",
               tag, skip_taken, ovf_clear, exp[1], exp[0]);
    end
  endtask

  // Caller is at a negedge; result checked at the following negedge.
  task automatic run(input string tag, input logic v, input logic [17:0] w,
      input logic [17:0] a, input logic [17:0] i, input logic o,
      input logic [5:0] f, input logic [5:0] s);
    logic [1:0] exp;
    instr_valid = v; instr = w; acc = a; io = i; ovf = o; flags = f; switches = s;
    exp = model(v, w, a, i, o, f, s);
    @(posedge clk);
    @(negedge clk);
    compare(tag, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0; acc = '0; io = '0;
    ovf = 1'b0; flags = '0; switches = '0;
    repeat (3) @(negedge clk);
    compare("R10 reset", 2'b00);
    rst_n = 1'b1;

    // R2
    run("R2 azero", 1, 18'o640100, 18'o0, 18'o5, 1, 6'h3f, 6'h3f);
    run("R2 azero no", 1, 18'o640100, 18'o5, 18'o5, 1, 6'h3f, 6'h3f);
    run("R2 apos", 1, 18'o640200, 18'o377777, 18'o0, 1, 6'h3f, 6'h3f);
    run("R2 aneg", 1, 18'o640400, 18'o400000, 18'o0, 1, 6'h3f, 6'h3f);
    // R3
    run("R3 ipos", 1, 18'o642000, 18'o0, 18'o777777, 1, 6'h3f, 6'h3f);
    run("R3 inz", 1, 18'o644000, 18'o0, 18'o1, 1, 6'h3f, 6'h3f);
    // R4 and R9
    run("R4 ovf clear", 1, 18'o641000, 18'o1, 18'o0, 0, 6'h3f, 6'h3f);
    run("R9 ovf set no skip", 1, 18'o641000, 18'o1, 18'o0, 1, 6'h3f, 6'h3f);
    run("R9 inverted", 1, 18'o651000, 18'o1, 18'o0, 0, 6'h3f, 6'h3f);
    // R5
    run("R5 flag3 off", 1, 18'o640003, 18'o1, 18'o0, 1, 6'b111011, 6'h3f);
    run("R5 flag3 on", 1, 18'o640003, 18'o1, 18'o0, 1, 6'b000100, 6'h3f);
    run("R5 all off", 1, 18'o640007, 18'o1, 18'o0, 1, 6'b000000, 6'h3f);
    run("R5 all one on", 1, 18'o640007, 18'o1, 18'o0, 1, 6'b100000, 6'h3f);
    run("R5 code0", 1, 18'o640000, 18'o1, 18'o0, 1, 6'b000000, 6'h3f);
    // R6
    run("R6 sw6 off", 1, 18'o640060, 18'o1, 18'o0, 1, 6'h3f, 6'b011111);
    run("R6 all off", 1, 18'o640070, 18'o1, 18'o0, 1, 6'h3f, 6'b000000);
    run("R6 code0", 1, 18'o640000, 18'o1, 18'o0, 1, 6'h3f, 6'b000000);
    // R7
    run("R7 or", 1, 18'o644200, 18'o400000, 18'o3, 1, 6'h3f, 6'h3f);
    run("R7 none true", 1, 18'o644200, 18'o400000, 18'o0, 1, 6'h3f, 6'h3f);
    // R8
    run("R8 inv or", 1, 18'o654200, 18'o400000, 18'o0, 1, 6'h3f, 6'h3f);
    run("R8 inv empty", 1, 18'o650000, 18'o0, 18'o0, 1, 6'h3f, 6'h3f);
    // R1
    run("R1 other opc", 1, 18'o661100, 18'o0, 18'o0, 0, 6'h0, 6'h0);
    // R10 pulse ends
    run("R10 idle", 0, 18'o641100, 18'o0, 18'o0, 0, 6'h0, 6'h0);

    for (int n = 0; n < 3000; n++) begin
      logic [17:0] w, a, i;
      w = 18'($urandom);
      if ($urandom_range(9) < 8) w[17:13] = 5'b11010;
      a = ($urandom_range(3) == 0) ? 18'o0 : 18'($urandom);
      i = ($urandom_range(3) == 0) ? 18'o0 : 18'($urandom);
      run("R7 random", $urandom_range(7) != 0, w, a, i, 1'($urandom),
          ($urandom_range(3) == 0) ? 6'h0 : 6'($urandom),
          ($urandom_range(3) == 0) ? 6'h0 : 6'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule